// File: doc/BRIEF.md
# Tile Grid Sizer

This block picks a tile shape for a tile-based renderer that works with one flat tile level, where the tile size is chosen per framebuffer. It takes a framebuffer width and height and chooses a power-of-two tile width and tile height for each axis on its own, so tiles may be rectangular. The rule keeps every axis at 64 tiles or fewer and never uses a tile side below 16 pixels. From the chosen shape the block derives three things: a packed size code, the number of tiles along each axis, and the byte sizes of the polygon list buffers that software must allocate.

A request carries both framebuffer dimensions on a valid/ready input stream. The block accepts one request, then runs a short sequential divide by 63 on both axes at the same time. It presents the result on a valid/ready output stream. Back-pressure works in both directions. The block holds `req_ready` low from the cycle it accepts a request until the consumer takes the response. The response holds steady for as long as `rsp_valid` is high and `rsp_ready` is low. A request with a zero dimension gives no response. Instead the block raises a one-cycle error pulse and is ready again at once.

Top module: `tile_grid_sizer`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. After a valid request is taken, `req_ready` stays low until the edge where `rsp_valid` and `rsp_ready` are both high. `req_ready` and `rsp_valid` are never high together.
- R2: For each axis, the tile side is the smallest power of two that is at least the framebuffer side divided by 63, taking the exact quotient, and it is raised to 16 if it would be smaller. The two axes are chosen independently.
- R3: Each tile side is no larger than the larger of 16 and its framebuffer side. The tile count on each axis is at most 64.
- R4: `size_code` bits [5:0] hold log2(tile_w/16) and bits [11:6] hold log2(tile_h/16).
- R5: `tiles_x` = ceil(fb_w/tile_w) and `tiles_y` = ceil(fb_h/tile_h).
- R6: `list_bytes` = 512 × (1 + tiles_x × tiles_y).
- R7: `hdr_offset` = 8 × tiles_x × tiles_y, rounded down to a multiple of 512.
- R8: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values and `rsp_valid` stays high.
- R9: A request taken with `fb_w` or `fb_h` equal to zero sets `err_zero` high for exactly the following cycle. It produces no response, and `req_ready` stays high.
- R10: The framebuffer inputs are sampled only at acceptance. Changing them while a request is in progress does not change its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| fb_w | input | 13 | Framebuffer width in pixels (1..4096) |
| fb_h | input | 13 | Framebuffer height in pixels (1..4096) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| tile_w | output | 13 | Chosen tile width in pixels |
| tile_h | output | 13 | Chosen tile height in pixels |
| size_code | output | 12 | Packed log2 tile size code |
| tiles_x | output | 7 | Tiles across |
| tiles_y | output | 7 | Tiles down |
| list_bytes | output | 23 | Total polygon list size in bytes |
| hdr_offset | output | 17 | Polygon list header offset in bytes |
| err_zero | output | 1 | One-cycle pulse for a rejected zero-size request |

## Verification
A fault in the divider's remainder or quotient state shows up first at framebuffer sides close to multiples of 63, such as 1008 and 1009. There the tile side jumps from 16 to 32, so a wrong quotient bit changes `tile_w`, `size_code` and the tile counts in the very first response. A stuck handshake state shows as `req_ready` and `rsp_valid` being high together, or as a response that changes during back-pressure. Both are visible within one cycle. Bad latching of the inputs shows only when the inputs are changed in the middle of a divide, so the stimulus does exactly that.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  parameter int FB_W      = 13;  // framebuffer side width, values up to 4096
  parameter int DIVISOR   = 63;  // keeps the tile count per axis under 64
  parameter int MIN_LOG   = 4;   // smallest tile side is 2**MIN_LOG
  parameter int FIELD_SH  = 6;   // position of the height field in the code
  parameter int BLK_LOG   = 9;   // polygon list block of 512 bytes
  parameter int ENTRY_LOG = 3;   // 8 header bytes per tile
  parameter int CNT_W     = 7;   // tile count width, up to 64

  localparam int CODE_W = 2 * FIELD_SH;
  localparam int PROD_W = 2 * CNT_W;
  localparam int LIST_W = PROD_W + BLK_LOG;
  localparam int OFF_W  = PROD_W + ENTRY_LOG;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DIV  = 2'd1,
    S_OUT  = 2'd2
  } tgs_state_t;
endpackage

// File: rtl/tgs_cdiv.sv
// Restoring divider by a constant, one quotient bit per cycle.
module tgs_cdiv #(
  parameter int W       = 13,
  parameter int DIVISOR = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  output logic         done,
  output logic [W-1:0] quo,
  output logic         rem_nz
);
  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int CW = $clog2(W + 1);
  localparam logic [RW-1:0] DV = RW'(DIVISOR);
  localparam logic [CW-1:0] STEPS = CW'(W);

  logic [W-1:0]  acc;
  logic [RW-1:0] rem;
  logic [CW-1:0] cnt;
  logic [RW-1:0] trial;

  assign trial = {rem[RW-2:0], acc[W-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      rem <= '0;
      cnt <= '0;
    end else if (load) begin
      acc <= num;
      rem <= '0;
      cnt <= STEPS;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (trial >= DV) begin
        rem <= trial - DV;
        acc <= {acc[W-2:0], 1'b1};
      end else begin
        rem <= trial;
        acc <= {acc[W-2:0], 1'b0};
      end
    end
  end

  assign done   = (cnt == '0);
  assign quo    = acc;
  assign rem_nz = (rem != '0);
endmodule

// File: rtl/tgs_axis.sv
// Per-axis tile side selection: power-of-two round-up, floor clamp, count.
module tgs_axis #(
  parameter int W       = 13,
  parameter int MIN_LOG = 4,
  parameter int LOG_W   = 6,
  parameter int CNT_W   = 7
) (
  input  logic [W-1:0]     fb,
  input  logic [W-1:0]     quo,
  input  logic             rem_nz,
  output logic [W-1:0]     tile,
  output logic [LOG_W-1:0] lg,
  output logic [CNT_W-1:0] count
);
  localparam int IW = $clog2(W) + 1;

  logic [W:0]    ceil_q;
  logic [IW-1:0] lead;
  logic [IW-1:0] up_log;
  logic [IW-1:0] t_log;
  logic [W:0]    below;
  logic [W-1:0]  mask;
  logic [W-1:0]  whole;

  assign ceil_q = {1'b0, quo} + {{W{1'b0}}, rem_nz};

  // leading-one detector
  always_comb begin
    lead = '0;
    for (int i = 0; i <= W; i++) begin
      if (ceil_q[i]) lead = IW'(i);
    end
  end

  // any set bit under the leading one means round up
  always_comb begin
    below = ceil_q & ~((W+1)'(1) << lead);
    up_log = (below != '0) ? lead + 1'b1 : lead;
    t_log  = (up_log < IW'(MIN_LOG)) ? IW'(MIN_LOG) : up_log;
  end

  assign tile  = W'(1) << t_log;
  assign lg    = LOG_W'(t_log - IW'(MIN_LOG));
  assign mask  = tile - 1'b1;
  assign whole = fb >> t_log;
  assign count = CNT_W'(whole) + CNT_W'((fb & mask) != '0);
endmodule

// File: rtl/tile_grid_sizer.sv
module tile_grid_sizer
  import tgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FB_W-1:0]   fb_w,
  input  logic [FB_W-1:0]   fb_h,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [FB_W-1:0]   tile_w,
  output logic [FB_W-1:0]   tile_h,
  output logic [CODE_W-1:0] size_code,
  output logic [CNT_W-1:0]  tiles_x,
  output logic [CNT_W-1:0]  tiles_y,
  output logic [LIST_W-1:0] list_bytes,
  output logic [OFF_W-1:0]  hdr_offset,
  output logic              err_zero
);
  tgs_state_t state;

  logic accept, is_zero, start;
  logic [FB_W-1:0] side_q [2];
  logic [FB_W-1:0] side_in [2];
  logic [FB_W-1:0] quo [2];
  logic            rnz [2];
  logic            dv_done [2];
  logic [FB_W-1:0] tile [2];
  logic [FIELD_SH-1:0] lg [2];
  logic [CNT_W-1:0] cnt [2];
  logic [PROD_W-1:0] prod;
  logic [LIST_W-1:0] list_n;
  logic [OFF_W-1:0]  off_n;

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_OUT);
  assign accept    = req_valid && req_ready;
  assign is_zero   = (fb_w == '0) || (fb_h == '0);
  assign start     = accept && !is_zero;
  assign side_in[0] = fb_w;
  assign side_in[1] = fb_h;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rst_n)     side_q[a] <= '0;
      else if (start) side_q[a] <= side_in[a];
    end

    tgs_cdiv #(.W(FB_W), .DIVISOR(DIVISOR)) u_div (
      .clk(clk), .rst_n(rst_n), .load(start), .num(side_in[a]),
      .done(dv_done[a]), .quo(quo[a]), .rem_nz(rnz[a])
    );

    tgs_axis #(.W(FB_W), .MIN_LOG(MIN_LOG), .LOG_W(FIELD_SH), .CNT_W(CNT_W)) u_pick (
      .fb(side_q[a]), .quo(quo[a]), .rem_nz(rnz[a]),
      .tile(tile[a]), .lg(lg[a]), .count(cnt[a])
    );
  end

  assign prod   = PROD_W'(cnt[0]) * PROD_W'(cnt[1]);
  assign list_n = (LIST_W'(prod) + 1'b1) << BLK_LOG;
  assign off_n  = (OFF_W'(prod) << ENTRY_LOG) & ~((OFF_W'(1) << BLK_LOG) - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      err_zero   <= 1'b0;
      tile_w     <= '0;
      tile_h     <= '0;
      size_code  <= '0;
      tiles_x    <= '0;
      tiles_y    <= '0;
      list_bytes <= '0;
      hdr_offset <= '0;
    end else begin
      err_zero <= accept && is_zero;
      case (state)
        S_IDLE: if (start) state <= S_DIV;
        S_DIV: if (dv_done[0] && dv_done[1]) begin
          state      <= S_OUT;
          tile_w     <= tile[0];
          tile_h     <= tile[1];
          size_code  <= {lg[1], lg[0]};
          tiles_x    <= cnt[0];
          tiles_y    <= cnt[1];
          list_bytes <= list_n;
          hdr_offset <= off_n;
        end
        S_OUT: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tgs_chk.sv
module tgs_chk
  import tgs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FB_W-1:0]   fb_w,
  input logic [FB_W-1:0]   fb_h,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [FB_W-1:0]   tile_w,
  input logic [FB_W-1:0]   tile_h,
  input logic [CNT_W-1:0]  tiles_x,
  input logic [CNT_W-1:0]  tiles_y,
  input logic [LIST_W-1:0] list_bytes,
  input logic [OFF_W-1:0]  hdr_offset,
  input logic              err_zero
);
  // R1
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  // R1
  hs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(tile_w) && $stable(tile_h)
      && $stable(list_bytes) && $stable(hdr_offset) && $stable(tiles_x) && $stable(tiles_y));
  // R2
  tile_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(tile_w) == 1 && $countones(tile_h) == 1
      && tile_w >= FB_W'(16) && tile_h >= FB_W'(16));
  // R3
  tile_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> tiles_x <= CNT_W'(64) && tiles_y <= CNT_W'(64) && tiles_x != '0 && tiles_y != '0);
  // R6 R7
  block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> list_bytes[BLK_LOG-1:0] == '0 && hdr_offset[BLK_LOG-1:0] == '0);
  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (fb_w == '0 || fb_h == '0) |=> err_zero && req_ready && !rsp_valid);
endmodule

bind tile_grid_sizer tgs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .fb_w(fb_w), .fb_h(fb_h), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .tile_w(tile_w), .tile_h(tile_h), .tiles_x(tiles_x), .tiles_y(tiles_y),
  .list_bytes(list_bytes), .hdr_offset(hdr_offset), .err_zero(err_zero)
);

// File: tb/sim_tile_grid_sizer.sv
module sim_tile_grid_sizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [12:0] fb_w = '0, fb_h = '0;
  logic req_ready, rsp_valid, err_zero;
  logic [12:0] tile_w, tile_h;
  logic [11:0] size_code;
  logic [6:0]  tiles_x, tiles_y;
  logic [22:0] list_bytes;
  logic [16:0] hdr_offset;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  tile_grid_sizer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .fb_w(fb_w), .fb_h(fb_h), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .tile_w(tile_w), .tile_h(tile_h), .size_code(size_code),
    .tiles_x(tiles_x), .tiles_y(tiles_y), .list_bytes(list_bytes),
    .hdr_offset(hdr_offset), .err_zero(err_zero)
  );

  function automatic int exp_tile(int fb);
    int q = (fb + 62) / 63;
    int t = 16;
    while (t < q) t = t * 2;
    return t;
  endfunction

  function automatic int lg16(int t);
    int n = 0;
    while ((16 << n) < t) n++;
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rsp(int w, int h);
    int tw = exp_tile(w), th = exp_tile(h);
    int tx = (w + tw - 1) / tw, ty = (h + th - 1) / th;
    int p = tx * ty;
    chk(tile_w == 13'(tw), "R2 tile_w", int'(tile_w), tw);
    chk(tile_h == 13'(th), "R2 tile_h", int'(tile_h), th);
    chk(int'(tile_w) <= ((w > 16) ? w : 16) && tx <= 64 && ty <= 64,
        "R3 bound", int'(tile_w), tw);
    chk(size_code == 12'((lg16(th) << 6) | lg16(tw)), "R4 code",
        int'(size_code), (lg16(th) << 6) | lg16(tw));
    chk(tiles_x == 7'(tx) && tiles_y == 7'(ty), "R5 counts",
        int'(tiles_x) * 100 + int'(tiles_y), tx * 100 + ty);
    chk(list_bytes == 23'(512 * (1 + p)), "R6 list", int'(list_bytes), 512 * (1 + p));
    chk(hdr_offset == 17'((8 * p) / 512 * 512), "R7 offset", int'(hdr_offset), (8 * p) / 512 * 512);
  endtask

  // one request; stall cycles of back-pressure; scramble inputs mid-flight
  task automatic run_req(int w, int h, int stall, bit scramble);
    fb_w = 13'(w); fb_h = 13'(h); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low while busy", int'(req_ready), 0);
    if (scramble) begin fb_w = 13'h1fff; fb_h = 13'd1; end  // R10
    while (!rsp_valid) @(negedge clk);
    check_rsp(w, h);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready, "R8 held valid", int'(rsp_valid), 1);
      check_rsp(w, h);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R1 ready after take", int'(req_ready), 1);
  endtask

  task automatic run_zero(int w, int h);
    fb_w = 13'(w); fb_h = 13'(h); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_zero && !rsp_valid && req_ready, "R9 error pulse", int'(err_zero), 1);
    @(negedge clk);
    chk(!err_zero && !rsp_valid, "R9 pulse one cycle", int'(err_zero), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !err_zero, "R1 reset state", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    run_req(1, 1, 0, 0);
    run_req(16, 16, 2, 0);
    run_req(4096, 4096, 3, 1);
    run_req(1008, 1009, 0, 0);
    run_req(1040, 17, 1, 1);
    run_req(4096, 1, 0, 0);
    run_req(2017, 4095, 0, 1);
    run_zero(0, 5);
    run_zero(7, 0);
    run_req(640, 480, 0, 0);
    for (int i = 0; i < 150; i++)
      run_req($urandom_range(4096, 1), $urandom_range(4096, 1),
              $urandom_range(2, 0), 1'($urandom_range(1, 0)));
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule